// File: doc/BRIEF.md
# Banked Data Address Generator

This block produces the data memory address used by register-operand instructions in a small 8-bit processor. An instruction supplies an 8-bit register offset and a bit that chooses how the offset is placed in the 12-bit data space. When that bit selects banked mode, a 4-bit bank register is prepended to the offset. When it selects the fixed window, the offset lands in a split region. The lower part of that region sits at the bottom of memory and the upper part sits at the top, where the special registers live.

Move-between-registers instructions carry a complete 12-bit address. A separate select routes that address straight to the output, and the bank register has no part in it. The block also resolves where a result is written: to the working register or back to the file register. That choice comes from an explicit direction bit when the instruction has one, and from a fixed per-instruction choice when it does not.

The bank register is loaded through its own write strobe. Both the address and the destination select are combinational, formed from the current inputs and the registered bank value.

Top module: `bank_addr_gen`

## Requirements
- R1: After reset the bank register holds 0, so a banked access with offset 0x34 produces address 0x034.
- R2: With `long_en`=0 and `use_bank`=1, `eff_addr` equals the bank register in bits 11:8 and `opnd_ofs` in bits 7:0.
- R3: With `long_en`=0, `use_bank`=0 and `opnd_ofs` below 0x60, `eff_addr` is 0x000 plus the offset, whatever the bank register holds.
- R4: With `long_en`=0, `use_bank`=0 and `opnd_ofs` of 0x60 or above, `eff_addr` is 0xF00 plus the offset, whatever the bank register holds.
- R5: With `long_en`=1, `eff_addr` equals `long_addr`, whatever the values of the bank register, `use_bank` and `opnd_ofs`.
- R6: When `bsel_we`=1 at a rising clock edge, the bank register takes `bsel_din`. The address formed during the cycle of the write still uses the old bank. The new bank is used from the next cycle on.
- R7: While `bsel_we`=0, the bank register keeps its value across clock edges, whatever `bsel_din` holds.
- R8: With `has_dir`=1, `to_file` equals `dir_bit`, where 1 means file register and 0 means working register. `impl_file` is ignored.
- R9: With `has_dir`=0, `to_file` equals `impl_file`, and `dir_bit` is ignored.
- R10: `eff_addr` and `to_file` follow input changes within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bsel_we | input | 1 | Bank register write strobe |
| bsel_din | input | 4 | New bank value |
| opnd_ofs | input | 8 | Register offset from the opcode |
| use_bank | input | 1 | 1 = banked mode, 0 = fixed split window |
| long_en | input | 1 | 1 = use the full 12-bit address |
| long_addr | input | 12 | Full address from move instructions |
| has_dir | input | 1 | Instruction carries a direction bit |
| dir_bit | input | 1 | Direction bit (1 = file, 0 = working) |
| impl_file | input | 1 | Implicit destination (1 = file, 0 = working) |
| eff_addr | output | 12 | Effective data address |
| to_file | output | 1 | 1 = result goes to the file register |

## Verification
A bank register write and a banked address formation can occur in the same cycle. The bench raises the write strobe with a new bank value while a banked offset is presented. Between the clock edges it checks that the address still carries the old bank, and after the edge it checks that the address carries the new one. The same overlap is also driven while the full-address path or the split window is selected. In those cases the output must not change at all across the write.

// File: rtl/bank_addr_gen.sv
module bank_addr_gen #(
  parameter int BANK_W = 4,
  parameter int OFS_W = 8,
  parameter int SPLIT = 8'h60
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bsel_we,
  input  logic [BANK_W-1:0]         bsel_din,
  input  logic [OFS_W-1:0]          opnd_ofs,
  input  logic                      use_bank,
  input  logic                      long_en,
  input  logic [BANK_W+OFS_W-1:0]   long_addr,
  input  logic                      has_dir,
  input  logic                      dir_bit,
  input  logic                      impl_file,
  output logic [BANK_W+OFS_W-1:0]   eff_addr,
  output logic                      to_file
);
  localparam int ADDR_W = BANK_W + OFS_W;

  logic [BANK_W-1:0] bank_q;
  logic              hi_win;
  logic [BANK_W-1:0] win_top;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bank_q <= '0;
    else if (bsel_we) bank_q <= bsel_din;

  assign hi_win  = (opnd_ofs >= OFS_W'(SPLIT));
  assign win_top = hi_win ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

  assign eff_addr = long_en  ? long_addr :
                    use_bank ? {bank_q, opnd_ofs} :
                               {win_top, opnd_ofs};

  assign to_file = has_dir ? dir_bit : impl_file;

  a_r6_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    bsel_we |=> bank_q == $past(bsel_din));
  a_r7_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bsel_we |=> $stable(bank_q));
  a_r3_low_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_en && !use_bank && opnd_ofs < OFS_W'(SPLIT)) |-> eff_addr[ADDR_W-1:OFS_W] == '0);
  a_r4_high_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_en && !use_bank && opnd_ofs >= OFS_W'(SPLIT)) |-> eff_addr[ADDR_W-1:OFS_W] == '1);
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !long_en |-> eff_addr[OFS_W-1:0] == opnd_ofs);
  a_r5_long_pass: assert property (@(posedge clk) disable iff (!rst_n)
    long_en |-> eff_addr == long_addr);
  a_r8_dir_sel: assert property (@(posedge clk) disable iff (!rst_n)
    has_dir |-> to_file == dir_bit);
endmodule

// File: tb/tb_bank_addr_gen.sv
module tb_bank_addr_gen;
  logic clk = 0, rst_n = 0;
  logic bsel_we = 0;
  logic [3:0] bsel_din = 0;
  logic [7:0] opnd_ofs = 0;
  logic use_bank = 0, long_en = 0, has_dir = 0, dir_bit = 0, impl_file = 0;
  logic [11:0] long_addr = 0;
  logic [11:0] eff_addr;
  logic to_file;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bank_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .bsel_we(bsel_we), .bsel_din(bsel_din),
    .opnd_ofs(opnd_ofs), .use_bank(use_bank), .long_en(long_en),
    .long_addr(long_addr), .has_dir(has_dir), .dir_bit(dir_bit),
    .impl_file(impl_file), .eff_addr(eff_addr), .to_file(to_file)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic set_bank(input logic [3:0] b);
    @(negedge clk); bsel_we = 1; bsel_din = b;
    @(negedge clk); bsel_we = 0;
  endtask

  task automatic t_reset;
    @(negedge clk); long_en = 0; use_bank = 1; opnd_ofs = 8'h34; #1;
    chk("R1 reset bank", eff_addr, 12'h034);
  endtask

  task automatic t_banked;
    set_bank(4'h5);
    long_en = 0; use_bank = 1; opnd_ofs = 8'hA7; #1;
    chk("R2 banked 5", eff_addr, 12'h5A7);
    set_bank(4'hE);
    opnd_ofs = 8'h00; #1;
    chk("R2 banked E", eff_addr, 12'hE00);
  endtask

  task automatic t_window;
    set_bank(4'h9);
    long_en = 0; use_bank = 0;
    opnd_ofs = 8'h5F; #1; chk("R3 low edge", eff_addr, 12'h05F);
    opnd_ofs = 8'h00; #1; chk("R3 low zero", eff_addr, 12'h000);
    opnd_ofs = 8'h60; #1; chk("R4 high edge", eff_addr, 12'hF60);
    opnd_ofs = 8'hFF; #1; chk("R4 high top", eff_addr, 12'hFFF);
  endtask

  task automatic t_long;
    set_bank(4'hA);
    long_en = 1; long_addr = 12'h3C5; use_bank = 1; opnd_ofs = 8'h11; #1;
    chk("R5 long banked", eff_addr, 12'h3C5);
    use_bank = 0; opnd_ofs = 8'h70; #1;
    chk("R5 long window", eff_addr, 12'h3C5);
    long_en = 0;
  endtask

  task automatic t_same_cycle;
    set_bank(4'h2);
    @(negedge clk); long_en = 0; use_bank = 1; opnd_ofs = 8'h44;
    bsel_we = 1; bsel_din = 4'hB; #1;
    chk("R6 old bank during write", eff_addr, 12'h244);
    @(negedge clk); bsel_we = 0; #1;
    chk("R6 new bank after write", eff_addr, 12'hB44);
    @(negedge clk); long_en = 1; long_addr = 12'h7E1; bsel_we = 1; bsel_din = 4'h3; #1;
    chk("R6 long during write", eff_addr, 12'h7E1);
    @(negedge clk); bsel_we = 0; #1;
    chk("R5 long after write", eff_addr, 12'h7E1);
    long_en = 0; use_bank = 0; opnd_ofs = 8'h20;
    @(negedge clk); bsel_we = 1; bsel_din = 4'h6; #1;
    chk("R3 window during write", eff_addr, 12'h020);
    @(negedge clk); bsel_we = 0; #1;
    chk("R3 window after write", eff_addr, 12'h020);
    use_bank = 1; #1;
    chk("R6 bank 6 seen", eff_addr, 12'h620);
  endtask

  task automatic t_hold;
    set_bank(4'hC);
    bsel_din = 4'h1; long_en = 0; use_bank = 1; opnd_ofs = 8'h0F;
    repeat (3) @(negedge clk);
    #1; chk("R7 hold", eff_addr, 12'hC0F);
  endtask

  task automatic t_dest;
    has_dir = 1; dir_bit = 1; impl_file = 0; #1; chk("R8 dir 1", to_file, 1);
    dir_bit = 0; impl_file = 1; #1; chk("R8 dir 0", to_file, 0);
    has_dir = 0; dir_bit = 1; impl_file = 0; #1; chk("R9 implicit 0", to_file, 0);
    dir_bit = 0; impl_file = 1; #1; chk("R9 implicit 1", to_file, 1);
  endtask

  task automatic t_comb;
    set_bank(4'h4);
    @(negedge clk); use_bank = 1; long_en = 0; opnd_ofs = 8'h10;
    @(posedge clk); #2; opnd_ofs = 8'h99; #1;
    chk("R10 addr mid-cycle", eff_addr, 12'h499);
    has_dir = 1; dir_bit = 1; #1;
    chk("R10 dest mid-cycle", to_file, 1);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset; t_banked; t_window; t_long; t_same_cycle; t_hold; t_dest; t_comb;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule